// File: doc/BRIEF.md
# PC Card Attribute-Space Configuration Registers

This block is the attribute-memory front end of a removable storage card that follows the CompactFlash register model. The host socket reads and writes it one byte at a time. Below the configuration base address it returns bytes from a small read-only card information table. The table is held in a parameter, so each product can supply its own contents. At the configuration base it provides three registers: an option register, a configuration status register and a pin replacement register. A socket/copy slot also sits there; it reads as zero and ignores writes.

The block also drives the level interrupt line back to the socket. The storage core signals a pending interrupt on a level input. That input is kept in the status register as an active-low flag. The flag is then gated by two bits of the ATA device-control register (interrupt mask and soft reset) and by the soft-reset bit of the option register. Writes to the device-control register arrive on a separate write port. The option register also supplies the addressing-mode field that the rest of the card uses to pick its memory or I/O decode. While the option soft-reset bit is set, the block holds the card in soft reset and drives the soft-reset output.

Top module: `pccard_cfg_regs`

## Requirements
- R1: After reset, attr_rdata, host_irq, card_soft_rst and addr_mode are 0. The option register reads 0x00 (memory-mapped mode). The status register reads 0x02: bit 1 is the active-low interrupt-pending flag, so it is 1 while idle.
- R2: A read at an attribute address below CFG_BASE (0x200) returns byte `a` of CIS_DATA when `a < CIS_LEN`, and 0x00 otherwise. Byte `a` is CIS_DATA[8a+7:8a]. Read data appears on attr_rdata in the cycle after the strobe.
- R3: A write to CFG_BASE+0 (option) stores the data ANDed with 0xCF, and a read returns that value. addr_mode equals option bits [1:0] and changes only on an option write.
- R4: While option bit 7 is set, card_soft_rst is 1 and the card is held in soft reset. In that state the status bits other than bit 1 are cleared, the pin register's ready flag is cleared, and the device-control bits are cleared. This takes effect from the cycle of the write that sets bit 7.
- R5: A write to CFG_BASE+2 (status) ORs the data ANDed with 0x74 into the register. A write never clears a bit.
- R6: A status write whose data differs from the stored value in bit 2 (power-down) sets the ready flag, which is bit 5 of the pin register.
- R7: While device-control bit 1 (interrupt mask) is set, a status read returns the register with bit 1 forced to 0.
- R8: A read of CFG_BASE+4 (pin replacement) returns the ready flag in bit 5, ORed with 0x0C. A write to it leaves the ready flag unchanged and stores data bit 1 as the host ready bit.
- R9: Status bit 1 takes the inverse of core_irq one clock after the core changes it, so a high core_irq clears the flag.
- R10: host_irq is 1 exactly when all of these hold: status bit 1 is 0, device-control bits 1 and 2 are both 0, and option bit 7 is 0. It updates one clock after the state it is derived from.
- R11: Reads of CFG_BASE+6 (socket/copy), of odd or higher offsets at or above CFG_BASE, and of addresses between CIS_LEN and CFG_BASE return 0x00. Writes to these addresses change no register.
- R12: A write on the device-control port stores data bits [2:1]. While bit 2 (soft reset) is set, card_soft_rst is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| attr_stb | input | 1 | Single-cycle attribute access strobe |
| attr_we | input | 1 | 1 = write, 0 = read for the strobed access |
| attr_addr | input | ADDR_W | Attribute byte address |
| attr_wdata | input | 8 | Write data |
| attr_rdata | output | 8 | Read data, valid the cycle after a read strobe |
| core_irq | input | 1 | Interrupt request level from the storage core |
| ctl_we | input | 1 | Device-control register write strobe |
| ctl_wdata | input | 8 | Device-control write data |
| host_irq | output | 1 | Level interrupt to the socket |
| card_soft_rst | output | 1 | Card soft reset in progress |
| addr_mode | output | 2 | Current addressing mode (option bits [1:0]) |

## Verification
The checker examines four behaviours on every cycle. The interrupt and the soft-reset output are never high together. A quiet core keeps the interrupt low. The mode output moves only after an option write. Soft-reset requests from either register reach the output two clocks later. It also checks the fixed pattern of pin-register reads and the zero value of unmapped reads. Some behaviours need the bench's scenarios to show them, because they only appear as values over time: the write masks, the one-way OR of status bits, the ready flag raised by a power-down change, the masked status read and the contents of the information table. The bench compares these against its own model after random and directed accesses.

// File: rtl/pccfg_pkg.sv
`timescale 1ns/1ps
package pccfg_pkg;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CIS,
    SEL_OPT,
    SEL_STAT,
    SEL_PIN,
    SEL_SOCK
  } sel_e;

  // offsets from the configuration base
  localparam int OFF_OPT  = 0;
  localparam int OFF_STAT = 2;
  localparam int OFF_PIN  = 4;
  localparam int OFF_SOCK = 6;

  localparam logic [7:0] OPT_WMASK  = 8'hCF;
  localparam logic [7:0] STAT_WMASK = 8'h74;
  localparam logic [7:0] PIN_FIXED  = 8'h0C;
  localparam logic [7:0] STAT_INIT  = 8'h02;

  localparam int OPT_SRST_BIT   = 7;
  localparam int STAT_INTN_BIT  = 1;
  localparam int STAT_PWRDN_BIT = 2;
  localparam int PIN_RDY_BIT    = 5;
  localparam int PIN_HRDY_BIT   = 1;
  localparam int CTL_MASK_BIT   = 1;
  localparam int CTL_SRST_BIT   = 2;

endpackage

// File: rtl/pccfg_cis_rom.sv
`timescale 1ns/1ps
module pccfg_cis_rom #(
  parameter int ADDR_W  = 10,
  parameter int CIS_LEN = 16,
  parameter logic [8*CIS_LEN-1:0] CIS_DATA = '0
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [7:0]        data
);
  localparam int IDX_W = (CIS_LEN > 1) ? $clog2(CIS_LEN) : 1;
  localparam logic [ADDR_W-1:0] LEN_A = ADDR_W'(CIS_LEN);

  logic [7:0] rom [CIS_LEN];

  for (genvar i = 0; i < CIS_LEN; i++) begin : g_rom
    assign rom[i] = CIS_DATA[8*i +: 8];
  end

  logic [IDX_W-1:0] idx;
  assign idx = addr[IDX_W-1:0];

  logic unused_hi;
  assign unused_hi = ^addr;

  always_comb begin
    if (addr < LEN_A) data = rom[idx];
    else              data = 8'h00;
  end
endmodule

// File: rtl/pccfg_addr_dec.sv
`timescale 1ns/1ps
module pccfg_addr_dec
  import pccfg_pkg::*;
#(
  parameter int ADDR_W   = 10,
  parameter int CFG_BASE = 'h200,
  parameter int CIS_LEN  = 16
) (
  input  logic [ADDR_W-1:0] addr,
  output sel_e              sel
);
  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(CFG_BASE);
  localparam logic [ADDR_W-1:0] LEN_A  = ADDR_W'(CIS_LEN);

  logic [ADDR_W-1:0] off;
  assign off = addr - BASE_A;

  always_comb begin
    sel = SEL_NONE;
    if (addr < BASE_A) begin
      if (addr < LEN_A) sel = SEL_CIS;
    end else begin
      case (off)
        ADDR_W'(OFF_OPT):  sel = SEL_OPT;
        ADDR_W'(OFF_STAT): sel = SEL_STAT;
        ADDR_W'(OFF_PIN):  sel = SEL_PIN;
        ADDR_W'(OFF_SOCK): sel = SEL_SOCK;
        default:           sel = SEL_NONE;
      endcase
    end
  end
endmodule

// File: rtl/pccfg_state.sv
`timescale 1ns/1ps
module pccfg_state
  import pccfg_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  sel_e       sel,
  input  logic [7:0] wdata,
  input  logic       core_irq,
  input  logic       ctl_we,
  input  logic [7:0] ctl_wdata,
  output logic [7:0] opt_q,
  output logic [7:0] stat_q,
  output logic       rdy_q,
  output logic       hrdy_q,
  output logic [1:0] ctl_q
);
  logic [7:0] opt_d, stat_d;
  logic       rdy_d, hrdy_d;
  logic [1:0] ctl_d;

  logic unused_ctl;
  assign unused_ctl = ^{ctl_wdata[7:3], ctl_wdata[0]};

  always_comb begin
    opt_d  = opt_q;
    stat_d = stat_q;
    rdy_d  = rdy_q;
    hrdy_d = hrdy_q;
    ctl_d  = ctl_q;

    if (ctl_we) ctl_d = ctl_wdata[CTL_SRST_BIT:CTL_MASK_BIT];

    if (wr_en) begin
      case (sel)
        SEL_OPT: opt_d = wdata & OPT_WMASK;
        SEL_STAT: begin
          if (stat_q[STAT_PWRDN_BIT] != wdata[STAT_PWRDN_BIT]) rdy_d = 1'b1;
          stat_d = stat_q | (wdata & STAT_WMASK);
        end
        SEL_PIN: hrdy_d = wdata[PIN_HRDY_BIT];
        default: ;
      endcase
    end

    // interrupt-pending flag is active low and follows the core
    stat_d[STAT_INTN_BIT] = ~core_irq;

    // option soft reset holds the rest of the card cleared
    if (opt_d[OPT_SRST_BIT]) begin
      stat_d = stat_d & (8'h01 << STAT_INTN_BIT);
      rdy_d  = 1'b0;
      hrdy_d = 1'b0;
      ctl_d  = 2'b00;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      opt_q  <= 8'h00;
      stat_q <= STAT_INIT;
      rdy_q  <= 1'b0;
      hrdy_q <= 1'b0;
      ctl_q  <= 2'b00;
    end else begin
      opt_q  <= opt_d;
      stat_q <= stat_d;
      rdy_q  <= rdy_d;
      hrdy_q <= hrdy_d;
      ctl_q  <= ctl_d;
    end
  end
endmodule

// File: rtl/pccfg_irq_gate.sv
`timescale 1ns/1ps
module pccfg_irq_gate (
  input  logic clk,
  input  logic rst,
  input  logic intn,
  input  logic ctl_mask,
  input  logic ctl_srst,
  input  logic opt_srst,
  output logic host_irq,
  output logic soft_rst
);
  always_ff @(posedge clk) begin
    if (rst) begin
      host_irq <= 1'b0;
      soft_rst <= 1'b0;
    end else begin
      host_irq <= ~intn & ~ctl_mask & ~ctl_srst & ~opt_srst;
      soft_rst <= opt_srst | ctl_srst;
    end
  end
endmodule

// File: rtl/pccard_cfg_regs.sv
`timescale 1ns/1ps
module pccard_cfg_regs
  import pccfg_pkg::*;
#(
  parameter int ADDR_W   = 10,
  parameter int CFG_BASE = 'h200,
  parameter int CIS_LEN  = 16,
  parameter logic [8*CIS_LEN-1:0] CIS_DATA =
    128'h0F02_0003_0105_1A01_0402_21FF_01D9_0401
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              attr_stb,
  input  logic              attr_we,
  input  logic [ADDR_W-1:0] attr_addr,
  input  logic [7:0]        attr_wdata,
  output logic [7:0]        attr_rdata,
  input  logic              core_irq,
  input  logic              ctl_we,
  input  logic [7:0]        ctl_wdata,
  output logic              host_irq,
  output logic              card_soft_rst,
  output logic [1:0]        addr_mode
);
  sel_e       sel;
  logic [7:0] cis_byte;
  logic [7:0] opt_q, stat_q;
  logic       rdy_q, hrdy_q;
  logic [1:0] ctl_q;
  logic [7:0] rd_mux;

  logic unused_hrdy;
  assign unused_hrdy = hrdy_q;

  pccfg_addr_dec #(.ADDR_W(ADDR_W), .CFG_BASE(CFG_BASE), .CIS_LEN(CIS_LEN)) u_dec (
    .addr (attr_addr),
    .sel  (sel)
  );

  pccfg_cis_rom #(.ADDR_W(ADDR_W), .CIS_LEN(CIS_LEN), .CIS_DATA(CIS_DATA)) u_rom (
    .addr (attr_addr),
    .data (cis_byte)
  );

  pccfg_state u_state (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (attr_stb & attr_we),
    .sel       (sel),
    .wdata     (attr_wdata),
    .core_irq  (core_irq),
    .ctl_we    (ctl_we),
    .ctl_wdata (ctl_wdata),
    .opt_q     (opt_q),
    .stat_q    (stat_q),
    .rdy_q     (rdy_q),
    .hrdy_q    (hrdy_q),
    .ctl_q     (ctl_q)
  );

  pccfg_irq_gate u_irq (
    .clk      (clk),
    .rst      (rst),
    .intn     (stat_q[STAT_INTN_BIT]),
    .ctl_mask (ctl_q[0]),
    .ctl_srst (ctl_q[1]),
    .opt_srst (opt_q[OPT_SRST_BIT]),
    .host_irq (host_irq),
    .soft_rst (card_soft_rst)
  );

  assign addr_mode = opt_q[1:0];

  always_comb begin
    case (sel)
      SEL_CIS:  rd_mux = cis_byte;
      SEL_OPT:  rd_mux = opt_q;
      SEL_STAT: rd_mux = ctl_q[0] ? (stat_q & ~(8'h01 << STAT_INTN_BIT)) : stat_q;
      SEL_PIN:  rd_mux = (8'(rdy_q) << PIN_RDY_BIT) | PIN_FIXED;
      default:  rd_mux = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)                      attr_rdata <= 8'h00;
    else if (attr_stb && !attr_we) attr_rdata <= rd_mux;
  end
endmodule

// File: rtl/pccard_cfg_regs_chk.sv
`timescale 1ns/1ps
module pccard_cfg_regs_chk #(
  parameter int ADDR_W   = 10,
  parameter int CFG_BASE = 'h200
) (
  input logic              clk,
  input logic              rst,
  input logic              attr_stb,
  input logic              attr_we,
  input logic [ADDR_W-1:0] attr_addr,
  input logic [7:0]        attr_wdata,
  input logic [7:0]        attr_rdata,
  input logic              core_irq,
  input logic              ctl_we,
  input logic [7:0]        ctl_wdata,
  input logic              host_irq,
  input logic              card_soft_rst,
  input logic [1:0]        addr_mode
);
  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(CFG_BASE);
  localparam logic [ADDR_W-1:0] PIN_A  = ADDR_W'(CFG_BASE + 4);
  localparam logic [ADDR_W-1:0] HIGH_A = ADDR_W'(CFG_BASE + 8);

  logic unused_bits;
  assign unused_bits = ^{attr_wdata[6:0], ctl_wdata[7:3], ctl_wdata[1:0]};

  // R10
  irq_soft_excl_chk: assert property (@(posedge clk) disable iff (rst)
    host_irq |-> !card_soft_rst);

  // R9
  quiet_core_chk: assert property (@(posedge clk) disable iff (rst)
    (!core_irq && !$past(core_irq)) |=> !host_irq);

  // R3
  mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(attr_stb && attr_we && attr_addr == BASE_A) |=> $stable(addr_mode));

  // R8
  pin_read_chk: assert property (@(posedge clk) disable iff (rst)
    (attr_stb && !attr_we && attr_addr == PIN_A) |=> ((attr_rdata & 8'hDF) == 8'h0C));

  // R11
  unmapped_read_chk: assert property (@(posedge clk) disable iff (rst)
    (attr_stb && !attr_we && attr_addr >= HIGH_A) |=> (attr_rdata == 8'h00));

  // R4
  opt_srst_chk: assert property (@(posedge clk) disable iff (rst)
    (attr_stb && attr_we && attr_addr == BASE_A && attr_wdata[7]) |-> ##2 card_soft_rst);

  // R12
  ctl_srst_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl_we && ctl_wdata[2]) |-> ##2 card_soft_rst);
endmodule

bind pccard_cfg_regs pccard_cfg_regs_chk #(.ADDR_W(ADDR_W), .CFG_BASE(CFG_BASE)) u_chk (.*);

// File: tb/pccard_cfg_regs_test.sv
`timescale 1ns/1ps
module pccard_cfg_regs_test;
  localparam int AW = 10;
  localparam logic [127:0] ROMV = 128'h0F02_0003_0105_1A01_0402_21FF_01D9_0401;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          attr_stb = 1'b0, attr_we = 1'b0;
  logic [AW-1:0] attr_addr = '0;
  logic [7:0]    attr_wdata = '0, attr_rdata;
  logic          core_irq = 1'b0, ctl_we = 1'b0;
  logic [7:0]    ctl_wdata = '0;
  logic          host_irq, card_soft_rst;
  logic [1:0]    addr_mode;

  always #2 clk = ~clk;

  pccard_cfg_regs uut (.*);

  int n_cmp = 0, n_bad = 0;
  logic [7:0] m_opt = 0, m_stat = 0;
  logic [1:0] m_ctl = 0;
  logic       m_rdy = 0;
  logic [7:0] rd;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] stat_full();
    return (m_stat & 8'hFD) | (core_irq ? 8'h00 : 8'h02);
  endfunction

  function automatic logic [7:0] exp_read(input logic [AW-1:0] a);
    logic [7:0] s;
    if (a < 10'h200) return (a < 16) ? ROMV[8*a +: 8] : 8'h00;
    s = stat_full();
    case (a - 10'h200)
      10'd0:   return m_opt;
      10'd2:   return m_ctl[0] ? (s & 8'hFD) : s;
      10'd4:   return (m_rdy ? 8'h20 : 8'h00) | 8'h0C;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic exp_irq();
    return core_irq && !m_ctl[0] && !m_ctl[1] && !m_opt[7];
  endfunction

  task automatic hold_model();
    if (m_opt[7]) begin m_stat = 0; m_rdy = 0; m_ctl = 0; end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] v);
    attr_stb = 1; attr_we = 1; attr_addr = a; attr_wdata = v;
    @(negedge clk);
    attr_stb = 0; attr_we = 0;
    if (a == 10'h200) m_opt = v & 8'hCF;
    else if (a == 10'h202) begin
      if ((stat_full() ^ v) & 8'h04) m_rdy = 1;
      m_stat = m_stat | (v & 8'h74);
    end
    hold_model();
  endtask

  task automatic rdreg(input logic [AW-1:0] a, output logic [7:0] d);
    attr_stb = 1; attr_we = 0; attr_addr = a;
    @(negedge clk);
    attr_stb = 0;
    d = attr_rdata;
  endtask

  task automatic ctl(input logic [7:0] v);
    ctl_we = 1; ctl_wdata = v;
    @(negedge clk);
    ctl_we = 0;
    m_ctl = v[2:1];
    hold_model();
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic chk_outs(input string tag);
    chk({tag, " R10 host_irq"}, {7'd0, host_irq}, {7'd0, exp_irq()});
    chk({tag, " R4/R12 soft_rst"}, {7'd0, card_soft_rst}, {7'd0, m_opt[7] | m_ctl[1]});
    chk({tag, " R3 addr_mode"}, {6'd0, addr_mode}, {6'd0, m_opt[1:0]});
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog (all requirements): got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [AW-1:0] a;
    logic [7:0]    v;
    void'($urandom(32'h1A2B));
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 rdata", attr_rdata, 8'h00);
    chk_outs("R1");
    rdreg(10'h200, rd); chk("R1 option", rd, 8'h00);
    rdreg(10'h202, rd); chk("R1 status", rd, 8'h02);
    // R2 table and gap
    rdreg(10'h000, rd); chk("R2 cis[0]", rd, exp_read(10'h000));
    rdreg(10'h00F, rd); chk("R2 cis[15]", rd, exp_read(10'h00F));
    rdreg(10'h010, rd); chk("R2 beyond table", rd, 8'h00);
    rdreg(10'h1FF, rd); chk("R11 gap", rd, 8'h00);
    // R3 / R4 option mask and soft reset
    wr(10'h200, 8'hFF); settle();
    rdreg(10'h200, rd); chk("R3 option mask", rd, 8'hCF);
    chk_outs("R4");
    wr(10'h200, 8'h01); settle();
    rdreg(10'h200, rd); chk("R3 option", rd, 8'h01);
    chk_outs("R3");
    // R5 / R6 status OR and power-down ready
    wr(10'h202, 8'h04);
    rdreg(10'h204, rd); chk("R6 ready flag", rd, 8'h2C);
    wr(10'h202, 8'h00);
    rdreg(10'h202, rd); chk("R5 no clear", rd, 8'h06);
    wr(10'h204, 8'h00);
    rdreg(10'h204, rd); chk("R8 ready kept", rd, 8'h2C);
    // R9 / R10 core interrupt
    core_irq = 1; settle(); @(negedge clk);
    rdreg(10'h202, rd); chk("R9 flag cleared", rd, 8'h04);
    chk_outs("R9");
    ctl(8'h02); settle();
    chk_outs("R12 mask");
    core_irq = 0; settle(); @(negedge clk);
    rdreg(10'h202, rd); chk("R7 masked read", rd, 8'h04);
    ctl(8'h00);
    // R11 socket and unmapped
    wr(10'h206, 8'hFF);
    rdreg(10'h206, rd); chk("R11 socket", rd, 8'h00);
    wr(10'h208, 8'hFF);
    rdreg(10'h208, rd); chk("R11 unmapped", rd, 8'h00);
    rdreg(10'h202, rd); chk("R11 status untouched", rd, exp_read(10'h202));
    // random mix
    for (int i = 0; i < 400; i++) begin
      case ($urandom_range(0, 6))
        0: a = 10'h200;
        1: a = 10'h202;
        2: a = 10'h204;
        3: a = 10'h206;
        4: a = 10'h208 + 10'($urandom_range(0, 'h1F7));
        5: a = 10'($urandom_range(0, 31));
        default: a = 10'($urandom_range(0, 'h1FF));
      endcase
      v = 8'($urandom_range(0, 255));
      case ($urandom_range(0, 4))
        0: begin
          if (a == 10'h200 && $urandom_range(0, 7) != 0) v[7] = 1'b0;
          wr(a, v);
        end
        1, 2: begin rdreg(a, rd); chk("R2/R5/R7/R8/R11 random read", rd, exp_read(a)); end
        3: ctl(($urandom_range(0, 3) == 0) ? v : (v & 8'hFB));
        default: core_irq = ~core_irq;
      endcase
      settle(); @(negedge clk);
      chk_outs("R9 random");
    end
    finish_run();
  end
endmodule